// File: doc/BRIEF.md
# DMA Request Arbiter

This block decides which of four DMA request lines is served next and drives a one-hot set of acknowledge lines back to the requesters. Each request is registered once on entry. The request is then converted to an internal active level and gated by a per-channel mask and by a global disable. A priority picker chooses one channel. The chosen acknowledge stays asserted until the transfer engine pulses a done strobe. No new decision is made while a grant is outstanding.

Software controls the block through a small host write port. An 8-bit command word sets several things: request polarity, acknowledge polarity, fixed or rotating priority, and the global disable. It also holds two datapath flags (memory-to-memory transfer and channel 0 address hold), which pass straight through to output pins. A separate mask word blocks individual channels. A software clear command returns the command word to zero and masks every channel, which is the same state that reset gives.

In rotating mode, the channel that was just served drops to the lowest priority when its done strobe arrives. In fixed mode, channel 0 always wins over the others.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset the command word is zero, all four channels are masked, no grant is held, `ack_pin` reads 4'b1111 (acknowledges idle high because they are active low), and both datapath flags are 0. A request made in this state is never granted.
- R2: With command bit 4 = 0 (fixed priority), the lowest-numbered eligible channel wins, with channel 0 highest.
- R3: With command bit 4 = 1 (rotating priority), a done strobe makes the channel one above the served channel (modulo 4) the highest priority, so the served channel becomes the lowest.
- R4: At most one acknowledge is active. A grant stays unchanged, whatever the requests do, until `done_i` is seen high at a clock edge.
- R5: While command bit 2 = 1, no new grant is issued. Clearing the bit lets pending requests be granted.
- R6: A masked channel is never granted. `host_sel` = 1 writes one mask bit: the channel number is in `host_data[1:0]` and the new mask value is in `host_data[2]`. `host_sel` = 2 writes all mask bits from `host_data[3:0]`, where 1 means masked.
- R7: Command bit 6 = 0 treats a request pin value of 1 as active; bit 6 = 1 treats 0 as active.
- R8: Command bit 7 = 0 drives an active acknowledge as 0 and idle as 1; bit 7 = 1 inverts this. The change shows on `ack_pin` right after the write, with no extra cycle.
- R9: A write with `host_sel` = 3 (software clear) sets the command word to zero and masks all channels.
- R10: `host_sel` = 0 loads the command word from `host_data`. Command bit 0 appears on `mem_to_mem` and bit 1 appears on `ch0_hold`.
- R11: A request applied before clock edge N is granted on edge N+1. A done strobe seen at an edge clears the grant at that edge. The earliest next grant comes one edge later.
- R12: When a done strobe and a command write fall on the same edge, the priority update uses the mode that was in effect before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Write target: 0 command, 1 single mask bit, 2 full mask, 3 software clear |
| host_data | input | 8 | Host write data |
| req_pin | input | 4 | Raw DMA request lines, polarity set by command bit 6 |
| done_i | input | 1 | Transfer-done strobe for the current grant |
| ack_pin | output | 4 | One-hot acknowledge lines, polarity set by command bit 7 |
| mem_to_mem | output | 1 | Stored command bit 0, for the datapath |
| ch0_hold | output | 1 | Stored command bit 1, for the datapath |

## Verification
Two functions can fall on the same edge: the done strobe that ends a rotating-mode grant, and a host write that switches the command word to fixed priority. The bench drives both on one clock edge, while channel 1 holds a grant and all four channels are requesting. It then restores rotating mode and re-raises all four requests. The design passes only if channel 2 wins, which shows that the pointer advanced under the mode that was in effect before the write. A design that looked at the new mode would grant channel 1 again.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int CMD_W        = 8;
    localparam int CMD_MEM2MEM  = 0;
    localparam int CMD_CH0_HOLD = 1;
    localparam int CMD_DISABLE  = 2;
    localparam int CMD_ROTATE   = 4;
    localparam int CMD_REQ_LOW  = 6;
    localparam int CMD_ACK_HIGH = 7;

    typedef enum logic [1:0] {
        HOST_CMD      = 2'd0,
        HOST_MASK_ONE = 2'd1,
        HOST_MASK_ALL = 2'd2,
        HOST_CLEAR    = 2'd3
    } host_sel_e;
endpackage

// File: rtl/dma_arb_regs.sv
module dma_arb_regs
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  host_sel_e         wr_sel,
    input  logic [CMD_W-1:0]  wr_data,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [NUM_CH-1:0] mask_o
);
    localparam int IDX_W = $clog2(NUM_CH);

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [NUM_CH-1:0] mask;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_sel)
                HOST_CMD:      st_d.cmd = wr_data;
                HOST_MASK_ONE: st_d.mask[wr_data[IDX_W-1:0]] = wr_data[IDX_W];
                HOST_MASK_ALL: st_d.mask = wr_data[NUM_CH-1:0];
                HOST_CLEAR: begin
                    st_d.cmd  = '0;
                    st_d.mask = '1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmd  <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o  = st_q.cmd;
    assign mask_o = st_q.mask;

    // R9
    clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == HOST_CLEAR) |=> (st_q.mask == '1 && st_q.cmd == '0));
endmodule

// File: rtl/dma_arb_reqin.sv
module dma_arb_reqin #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_pin,
    input  logic              req_low,
    output logic [NUM_CH-1:0] req_act
);
    logic [NUM_CH-1:0] raw_d, raw_q;

    always_comb raw_d = req_pin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

    assign req_act = raw_q ^ {NUM_CH{req_low}};
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
    parameter int NUM_CH = 4,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] elig,
    input  logic [IDX_W-1:0]  base_ptr,
    output logic              win_valid,
    output logic [IDX_W-1:0]  win_idx
);
    logic [IDX_W-1:0] cand;

    always_comb begin
        win_valid = |elig;
        win_idx   = '0;
        cand      = '0;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            cand = base_ptr + IDX_W'(k);
            if (elig[cand]) win_idx = cand;
        end
    end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_sel,
    input  logic [7:0]        host_data,
    input  logic [NUM_CH-1:0] req_pin,
    input  logic              done_i,
    output logic [NUM_CH-1:0] ack_pin,
    output logic              mem_to_mem,
    output logic              ch0_hold
);
    localparam int IDX_W = $clog2(NUM_CH);
    localparam logic [IDX_W-1:0]  ONE_IDX = 1;
    localparam logic [NUM_CH-1:0] ONE_CH  = 1;

    typedef struct packed {
        logic [NUM_CH-1:0] grant;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  ptr;
    } arb_t;

    arb_t st_d, st_q;

    logic [CMD_W-1:0]  cmd_q;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] req_act;
    logic [NUM_CH-1:0] elig;
    logic [IDX_W-1:0]  base_ptr;
    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;
    logic              unused_cmd_bits;

    dma_arb_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr),
        .wr_sel  (host_sel_e'(host_sel)),
        .wr_data (host_data),
        .cmd_o   (cmd_q),
        .mask_o  (mask_q)
    );

    dma_arb_reqin #(.NUM_CH(NUM_CH)) u_reqin (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_pin (req_pin),
        .req_low (cmd_q[CMD_REQ_LOW]),
        .req_act (req_act)
    );

    assign elig     = req_act & ~mask_q & {NUM_CH{~cmd_q[CMD_DISABLE]}};
    assign base_ptr = cmd_q[CMD_ROTATE] ? st_q.ptr : '0;

    dma_arb_pick #(.NUM_CH(NUM_CH)) u_pick (
        .elig      (elig),
        .base_ptr  (base_ptr),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.grant != '0) begin
            if (done_i) begin
                st_d.grant = '0;
                if (cmd_q[CMD_ROTATE]) st_d.ptr = st_q.idx + ONE_IDX;
            end
        end else if (win_valid) begin
            st_d.grant = ONE_CH << win_idx;
            st_d.idx   = win_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_pin         = cmd_q[CMD_ACK_HIGH] ? st_q.grant : ~st_q.grant;
    assign mem_to_mem      = cmd_q[CMD_MEM2MEM];
    assign ch0_hold        = cmd_q[CMD_CH0_HOLD];
    assign unused_cmd_bits = ^{cmd_q[3], cmd_q[5]};

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.grant));

    // R4
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.grant != '0 && !done_i) |=> $stable(st_q.grant));

    // R11
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.grant != '0 && done_i) |=> st_q.grant == '0);

    // R5
    disable_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.grant == '0 && cmd_q[CMD_DISABLE]) |=> st_q.grant == '0);

    // R6
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.grant == '0) |=> (st_q.grant & $past(mask_q)) == '0);

    // R3
    rotate_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.grant != '0 && done_i && cmd_q[CMD_ROTATE])
            |=> st_q.ptr == IDX_W'($past(st_q.idx) + ONE_IDX));
endmodule

// File: tb/dma_req_arbiter_bench.sv
`timescale 1ns/1ps
module dma_req_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic [7:0] host_data = 8'd0;
    logic [3:0] req_pin = 4'd0;
    logic       done_i = 1'b0;
    logic [3:0] ack_pin;
    logic       mem_to_mem;
    logic       ch0_hold;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dma_req_arbiter u_dma_req_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_sel   (host_sel),
        .host_data  (host_data),
        .req_pin    (req_pin),
        .done_i     (done_i),
        .ack_pin    (ack_pin),
        .mem_to_mem (mem_to_mem),
        .ch0_hold   (ch0_hold)
    );

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic host_write(logic [1:0] s, logic [7:0] d);
        host_wr = 1'b1; host_sel = s; host_data = d;
        tick(1);
        host_wr = 1'b0;
    endtask

    task automatic pulse_done();
        done_i = 1'b1;
        tick(1);
        done_i = 1'b0;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] ack_lo(int ch);
        return ~(4'b0001 << ch);
    endfunction

    task automatic t_reset();
        check("R1 idle ack", ack_pin, 4'hF);
        check("R1 mem_to_mem", mem_to_mem, 0);
        check("R1 ch0_hold", ch0_hold, 0);
        req_pin = 4'b0001; tick(3);
        check("R1 masked after reset", ack_pin, 4'hF);
        req_pin = 4'b0000; tick(1);
        host_write(2'd2, 8'h00);
    endtask

    task automatic t_fixed();
        req_pin = 4'b1110; tick(1);
        check("R11 not yet granted", ack_pin, 4'hF);
        tick(1);
        check("R2 lowest wins ch1", ack_pin, ack_lo(1));
        req_pin = 4'hF; tick(3);
        check("R4 grant held", ack_pin, ack_lo(1));
        pulse_done();
        check("R11 done releases", ack_pin, 4'hF);
        tick(1);
        check("R2 ch0 highest", ack_pin, ack_lo(0));
        req_pin = 4'h0; pulse_done(); tick(1);
        check("R11 idle after release", ack_pin, 4'hF);
    endtask

    task automatic t_rotate();
        host_write(2'd0, 8'h10);
        req_pin = 4'hF; tick(2);
        check("R3 first ch0", ack_pin, ack_lo(0));
        for (int i = 1; i <= 4; i++) begin
            pulse_done(); tick(1);
            check("R3 rotation", ack_pin, ack_lo(i % 4));
        end
        req_pin = 4'h0; pulse_done(); tick(1);
        host_write(2'd0, 8'h00);
    endtask

    task automatic t_disable();
        host_write(2'd0, 8'h04);
        req_pin = 4'b0001; tick(3);
        check("R5 disabled no grant", ack_pin, 4'hF);
        host_write(2'd0, 8'h00);
        tick(1);
        check("R5 enabled grants", ack_pin, ack_lo(0));
        req_pin = 4'h0; pulse_done(); tick(1);
    endtask

    task automatic t_mask();
        host_write(2'd1, 8'h04);
        req_pin = 4'b0001; tick(3);
        check("R6 single mask blocks ch0", ack_pin, 4'hF);
        req_pin = 4'b0011; tick(2);
        check("R6 ch1 over masked ch0", ack_pin, ack_lo(1));
        req_pin = 4'h0; pulse_done(); tick(1);
        host_write(2'd1, 8'h00);
        req_pin = 4'b0001; tick(2);
        check("R6 unmasked ch0", ack_pin, ack_lo(0));
        req_pin = 4'h0; pulse_done(); tick(1);
        host_write(2'd2, 8'h0F);
        req_pin = 4'hF; tick(3);
        check("R6 all masked", ack_pin, 4'hF);
        host_write(2'd2, 8'h07);
        tick(1);
        check("R6 only ch3 open", ack_pin, ack_lo(3));
        req_pin = 4'h0; pulse_done(); tick(1);
        host_write(2'd2, 8'h00);
    endtask

    task automatic t_polarity();
        req_pin = 4'hF;
        host_write(2'd0, 8'h40);
        tick(2);
        check("R7 high pins idle", ack_pin, 4'hF);
        req_pin = 4'b1011; tick(2);
        check("R7 low pin requests ch2", ack_pin, ack_lo(2));
        host_write(2'd0, 8'hC0);
        check("R8 ack active high", ack_pin, 4'b0100);
        req_pin = 4'hF; pulse_done();
        check("R8 idle ack low", ack_pin, 4'b0000);
        tick(2);
        check("R8 stays idle", ack_pin, 4'b0000);
        req_pin = 4'h0;
        host_write(2'd0, 8'h00);
        tick(2);
        check("R7 restored idle", ack_pin, 4'hF);
    endtask

    task automatic t_clear();
        host_write(2'd0, 8'h03);
        check("R10 mem_to_mem set", mem_to_mem, 1);
        check("R10 ch0_hold set", ch0_hold, 1);
        host_write(2'd0, 8'h02);
        check("R10 mem_to_mem clear", mem_to_mem, 0);
        check("R10 ch0_hold only", ch0_hold, 1);
        host_write(2'd0, 8'h81);
        check("R8 idle high polarity", ack_pin, 4'b0000);
        host_write(2'd3, 8'h00);
        check("R9 cmd cleared flags", {mem_to_mem, ch0_hold}, 0);
        check("R9 ack back to active low", ack_pin, 4'hF);
        req_pin = 4'b0001; tick(3);
        check("R9 masked after clear", ack_pin, 4'hF);
        host_write(2'd2, 8'h00);
        tick(1);
        check("R9 unmask grants", ack_pin, ack_lo(0));
        req_pin = 4'h0; pulse_done(); tick(1);
    endtask

    task automatic t_same_cycle();
        host_write(2'd0, 8'h10);
        req_pin = 4'b0001; tick(2);
        check("R3 single ch0", ack_pin, ack_lo(0));
        req_pin = 4'h0; pulse_done(); tick(1);
        req_pin = 4'hF; tick(2);
        check("R3 ch1 after ch0", ack_pin, ack_lo(1));
        req_pin = 4'h0;
        done_i = 1'b1; host_wr = 1'b1; host_sel = 2'd0; host_data = 8'h00;
        tick(1);
        done_i = 1'b0; host_wr = 1'b0;
        check("R12 release with write", ack_pin, 4'hF);
        tick(1);
        host_write(2'd0, 8'h10);
        req_pin = 4'hF; tick(2);
        check("R12 pointer used old mode", ack_pin, ack_lo(2));
        req_pin = 4'h0; pulse_done(); tick(1);
    endtask

    initial begin
        @(negedge clk);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_fixed();
        t_rotate();
        t_disable();
        t_mask();
        t_polarity();
        t_clear();
        t_same_cycle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule